// File: doc/BRIEF.md
# MDIO PHY Management Responder

This block answers serial management frames on a two-wire MDC/MDIO bus, presenting itself as a simple Ethernet PHY with a 32-entry by 16-bit register file. The management clock and the data line are brought into the system clock domain. The block decodes frames that carry a preamble, a start pattern, an opcode, a PHY address, a register address, a turnaround and sixteen data bits. It responds only to the PHY address set by a parameter.

Several registers are not read from storage. The status, link-partner, vendor-speed and diagnostic registers are formed at read time from the advertisement register and the `link_up` input, so any advertised mode always appears to have been negotiated successfully. Every accepted write stores its data and then forces the soft-reset bit of the control register back to zero.

Top module: `mdio_phy_responder`

## Requirements
- R1: After reset, register 0 reads 0x3100, register 2 reads 0x0300, register 3 reads 0xE400 and register 4 reads 0x01E1. Every other stored register reads 0, and the line is not driven.
- R2: Registers that are not computed (all except 1, 5, 17 and 18) read back the last value written to them, addressed by the 5-bit register field.
- R3: Register 1 reads 0x782E (bits 14, 13, 12, 11, 5, 3, 2, 1) while `link_up` is 1, and reads 0 while it is 0, whatever was written to it.
- R4: Register 5 reads 0x4000 OR (register 4 AND 0x01E0) OR 0x0001.
- R5: Register 17 always reads 0x8000.
- R6: Register 18 reads 0 while `link_up` is 0. While `link_up` is 1, bit 10 is set when register 4 has 0x0080 or 0x0100 set, and bit 11 is set when register 4 has 0x0100 or 0x0040 set. All other bits are 0.
- R7: Any accepted write clears bit 15 of register 0 after storing the data, so a write of 0x9140 to register 0 reads back 0x1140.
- R8: A frame is accepted only after at least PRE_LEN consecutive 1 bits (default 32), followed by start bits 0 then 1 and an opcode of 10 (read) or 01 (write). Then come the 5-bit PHY address, the 5-bit register address, 2 turnaround bits and 16 data bits, all MSB first and sampled on MDC rising edges. A frame with a shorter preamble is ignored.
- R9: On a read, the line stays released during the first turnaround bit and is driven 0 during the second. Data bits 15 to 0 follow, and the line is released after bit 0 has been sampled. Output changes occur only after an MDC rising edge.
- R10: A frame whose PHY address differs from PHY_ADDR (default 7) never drives the line and, if it is a write, changes no register.
- R11: A wrong second start bit or an opcode of 00 or 11 sends the decoder back to preamble search, so the rest of that frame is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples MDC |
| rst_n | input | 1 | Active-low asynchronous reset |
| mdc | input | 1 | Management clock from the station |
| mdio_i | input | 1 | Resolved level of the management data line |
| link_up | input | 1 | 1 while the modelled link is up |
| mdio_o | output | 1 | Value driven onto the data line when enabled |
| mdio_oe | output | 1 | 1 while this block drives the data line |

## Verification
A decoder that slips its field counter shows up at once as a wrong turnaround pattern or as data shifted by one bit within the same read frame. A bad address latch shows up as a response to a foreign PHY address, or as silence on its own. A stored value that is wrong, or a computed register that takes the wrong source, appears on the first read of that register after the fault. The read-back scoreboard catches it within one frame of about 64 MDC periods.

// File: rtl/mdio_resp_pkg.sv
package mdio_resp_pkg;

   localparam int unsigned REG_AW = 5;
   localparam int unsigned REG_DW = 16;
   localparam int unsigned NREGS  = 1 << REG_AW;

   typedef enum logic [2:0] {
      PH_PRE,
      PH_START,
      PH_OPC,
      PH_PHY,
      PH_REG,
      PH_TA,
      PH_DATA
   } mdio_phase_e;

   localparam logic [1:0] OPC_READ  = 2'b10;
   localparam logic [1:0] OPC_WRITE = 2'b01;

   localparam logic [REG_AW-1:0] IDX_CTRL    = 5'd0;
   localparam logic [REG_AW-1:0] IDX_STATUS  = 5'd1;
   localparam logic [REG_AW-1:0] IDX_ADV     = 5'd4;
   localparam logic [REG_AW-1:0] IDX_PARTNER = 5'd5;
   localparam logic [REG_AW-1:0] IDX_VENDOR  = 5'd17;
   localparam logic [REG_AW-1:0] IDX_DIAG    = 5'd18;

   localparam logic [REG_DW-1:0] STATUS_LINK_UP = 16'h782E;
   localparam logic [REG_DW-1:0] VENDOR_SPEED   = 16'h8000;
   localparam logic [REG_DW-1:0] PARTNER_FIXED  = 16'h4001;
   localparam logic [REG_DW-1:0] ADV_MODE_MASK  = 16'h01E0;

   function automatic logic [REG_DW-1:0] reset_value(input int unsigned idx);
      case (idx)
         0:       return 16'h3100;
         2:       return 16'h0300;
         3:       return 16'hE400;
         4:       return 16'h01E1;
         default: return '0;
      endcase
   endfunction

endpackage

// File: rtl/mdio_in_sync.sv
module mdio_in_sync #(
   parameter int          STAGES  = 2,
   parameter int          W       = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stage_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
            end else begin
               stage_q[0] <= d;
               for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
            end
         end
         assign q = stage_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
   import mdio_resp_pkg::*;
#(
   parameter int PHY_ADDR = 7,
   parameter int PRE_LEN  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_evt,
   input  logic              bit_val,
   input  logic [REG_DW-1:0] rd_data,
   output logic [REG_AW-1:0] rd_addr,
   output logic              wr_en,
   output logic [REG_AW-1:0] wr_addr,
   output logic [REG_DW-1:0] wr_data,
   output logic              drv_oe,
   output logic              drv_val
);

   localparam int PCW = $clog2(PRE_LEN + 1);
   localparam logic [PCW-1:0]    PRE_FULL = PCW'(PRE_LEN);
   localparam logic [REG_AW-1:0] MY_ADDR  = REG_AW'(PHY_ADDR);

   mdio_phase_e       phase_q;
   logic [PCW-1:0]    pre_cnt_q;
   logic [3:0]        bit_cnt_q;
   logic [1:0]        opc_q;
   logic [REG_AW-1:0] phy_q;
   logic [REG_AW-1:0] reg_q;
   logic [REG_DW-1:0] shift_q;
   logic              hit_q;

   assign rd_addr = reg_q;
   assign wr_addr = reg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_PRE;
         pre_cnt_q <= '0;
         bit_cnt_q <= '0;
         opc_q     <= '0;
         phy_q     <= '0;
         reg_q     <= '0;
         shift_q   <= '0;
         hit_q     <= 1'b0;
         wr_en     <= 1'b0;
         wr_data   <= '0;
         drv_oe    <= 1'b0;
         drv_val   <= 1'b1;
      end else begin
         wr_en <= 1'b0;
         if (bit_evt) begin
            case (phase_q)
               PH_PRE: begin
                  if (bit_val) begin
                     if (pre_cnt_q != PRE_FULL) pre_cnt_q <= pre_cnt_q + 1'b1;
                  end else begin
                     pre_cnt_q <= '0;
                     if (pre_cnt_q == PRE_FULL) phase_q <= PH_START;
                  end
               end
               PH_START: begin
                  bit_cnt_q <= '0;
                  phase_q   <= bit_val ? PH_OPC : PH_PRE;
               end
               PH_OPC: begin
                  opc_q <= {opc_q[0], bit_val};
                  if (bit_cnt_q == 4'd1) begin
                     bit_cnt_q <= '0;
                     if ({opc_q[0], bit_val} == OPC_READ || {opc_q[0], bit_val} == OPC_WRITE)
                        phase_q <= PH_PHY;
                     else
                        phase_q <= PH_PRE;
                  end else begin
                     bit_cnt_q <= bit_cnt_q + 1'b1;
                  end
               end
               PH_PHY: begin
                  phy_q <= {phy_q[REG_AW-2:0], bit_val};
                  if (bit_cnt_q == 4'(REG_AW - 1)) begin
                     bit_cnt_q <= '0;
                     phase_q   <= PH_REG;
                  end else begin
                     bit_cnt_q <= bit_cnt_q + 1'b1;
                  end
               end
               PH_REG: begin
                  reg_q <= {reg_q[REG_AW-2:0], bit_val};
                  if (bit_cnt_q == 4'(REG_AW - 1)) begin
                     bit_cnt_q <= '0;
                     hit_q     <= (phy_q == MY_ADDR);
                     phase_q   <= PH_TA;
                  end else begin
                     bit_cnt_q <= bit_cnt_q + 1'b1;
                  end
               end
               PH_TA: begin
                  if (bit_cnt_q == 4'd0) begin
                     bit_cnt_q <= 4'd1;
                     if (hit_q && opc_q == OPC_READ) begin
                        drv_oe  <= 1'b1;
                        drv_val <= 1'b0;
                        shift_q <= rd_data;
                     end
                  end else begin
                     bit_cnt_q <= '0;
                     phase_q   <= PH_DATA;
                     drv_val   <= shift_q[REG_DW-1];
                     shift_q   <= {shift_q[REG_DW-2:0], 1'b0};
                  end
               end
               PH_DATA: begin
                  shift_q <= {shift_q[REG_DW-2:0], bit_val};
                  drv_val <= shift_q[REG_DW-1];
                  if (bit_cnt_q == 4'(REG_DW - 1)) begin
                     bit_cnt_q <= '0;
                     phase_q   <= PH_PRE;
                     drv_oe    <= 1'b0;
                     drv_val   <= 1'b1;
                     if (hit_q && opc_q == OPC_WRITE) begin
                        wr_en   <= 1'b1;
                        wr_data <= {shift_q[REG_DW-2:0], bit_val};
                     end
                  end else begin
                     bit_cnt_q <= bit_cnt_q + 1'b1;
                  end
               end
               default: phase_q <= PH_PRE;
            endcase
         end
      end
   end

endmodule

// File: rtl/mdio_phy_regs.sv
module mdio_phy_regs
   import mdio_resp_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              link_up,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [REG_DW-1:0] wr_data,
   input  logic [REG_AW-1:0] rd_addr,
   output logic [REG_DW-1:0] rd_data,
   output logic [REG_DW-1:0] ctrl_q
);

   logic [REG_DW-1:0] store_q [NREGS];
   logic [REG_DW-1:0] adv;
   logic              spd100;
   logic              full_dx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREGS; i++) store_q[i] <= reset_value(i);
      end else if (wr_en) begin
         for (int i = 0; i < NREGS; i++) begin
            if (wr_addr == REG_AW'(i))
               store_q[i] <= (i == 0) ? {1'b0, wr_data[REG_DW-2:0]} : wr_data;
            else if (i == 0)
               store_q[i] <= {1'b0, store_q[i][REG_DW-2:0]};
         end
      end
   end

   assign adv     = store_q[IDX_ADV];
   assign spd100  = adv[7] | adv[8];
   assign full_dx = adv[8] | adv[6];
   assign ctrl_q  = store_q[IDX_CTRL];

   always_comb begin
      case (rd_addr)
         IDX_STATUS:  rd_data = link_up ? STATUS_LINK_UP : '0;
         IDX_PARTNER: rd_data = PARTNER_FIXED | (adv & ADV_MODE_MASK);
         IDX_VENDOR:  rd_data = VENDOR_SPEED;
         IDX_DIAG:    rd_data = link_up ? {4'b0, full_dx, spd100, 10'b0} : '0;
         default:     rd_data = store_q[rd_addr];
      endcase
   end

endmodule

// File: rtl/mdio_phy_responder.sv
module mdio_phy_responder
   import mdio_resp_pkg::*;
#(
   parameter int PHY_ADDR    = 7,
   parameter int PRE_LEN     = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mdc,
   input  logic mdio_i,
   input  logic link_up,
   output logic mdio_o,
   output logic mdio_oe
);

   generate
      if (PHY_ADDR < 0 || PHY_ADDR >= int'(NREGS)) begin : g_bad_addr
         $error("PHY_ADDR must fit in the 5-bit address field");
      end
      if (PRE_LEN < 1) begin : g_bad_pre
         $error("PRE_LEN must be at least 1");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   logic [1:0]        pins_s;
   logic              mdc_d;
   logic              mdc_rise;
   logic [REG_AW-1:0] rd_addr;
   logic [REG_DW-1:0] rd_data;
   logic              wr_en;
   logic [REG_AW-1:0] wr_addr;
   logic [REG_DW-1:0] wr_data;
   logic [REG_DW-1:0] ctrl_q;

   mdio_in_sync #(
      .STAGES (SYNC_STAGES),
      .W      (2),
      .RST_VAL(2'b01)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({mdc, mdio_i}),
      .q    (pins_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mdc_d <= 1'b0;
      else        mdc_d <= pins_s[1];
   end

   assign mdc_rise = pins_s[1] & ~mdc_d;

   mdio_frame_fsm #(
      .PHY_ADDR(PHY_ADDR),
      .PRE_LEN (PRE_LEN)
   ) u_fsm (
      .clk    (clk),
      .rst_n  (rst_n),
      .bit_evt(mdc_rise),
      .bit_val(pins_s[0]),
      .rd_data(rd_data),
      .rd_addr(rd_addr),
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .drv_oe (mdio_oe),
      .drv_val(mdio_o)
   );

   mdio_phy_regs u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .link_up(link_up),
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .rd_addr(rd_addr),
      .rd_data(rd_data),
      .ctrl_q (ctrl_q)
   );

endmodule

// File: rtl/mdio_phy_responder_chk.sv
module mdio_phy_responder_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        rise,
   input logic        link_up,
   input logic        mdio_oe,
   input logic        mdio_o,
   input logic        wr_en,
   input logic [15:0] ctrl_q,
   input logic [4:0]  rd_addr,
   input logic [15:0] rd_data
);

   p_ctrl_rst_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !ctrl_q[15]);

   p_status_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!link_up && rd_addr == 5'd1) |-> rd_data == 16'h0000);

   p_partner_fixed_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == 5'd5) |-> (rd_data[14] && rd_data[0]));

   p_vendor_const_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == 5'd17) |-> rd_data == 16'h8000);

   p_diag_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!link_up && rd_addr == 5'd18) |-> rd_data == 16'h0000);

   p_ta_low_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mdio_oe) |-> !mdio_o);

   p_oe_after_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mdio_oe != $past(mdio_oe)) |-> $past(rise));

endmodule

bind mdio_phy_responder mdio_phy_responder_chk u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .rise   (mdc_rise),
   .link_up(link_up),
   .mdio_oe(mdio_oe),
   .mdio_o (mdio_o),
   .wr_en  (wr_en),
   .ctrl_q (ctrl_q),
   .rd_addr(rd_addr),
   .rd_data(rd_data)
);

// File: tb/mdio_phy_responder_bench.sv
module mdio_phy_responder_bench;

   localparam int CLK_PERIOD = 10;
   localparam int HALF_BIT   = 4;
   localparam int PRE        = 32;
   localparam logic [4:0] ME    = 5'd7;
   localparam logic [4:0] OTHER = 5'd3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mdc = 1'b0;
   logic link_up = 1'b1;
   logic st_oe = 1'b0;
   logic st_o = 1'b1;
   logic dut_o, dut_oe;
   logic bus;
   logic oe_seen = 1'b0;
   logic done = 1'b0;

   int total = 0;
   int bad = 0;

   logic [15:0] exp_q [$];
   logic [15:0] got_q [$];
   string       tag_q [$];

   assign bus = dut_oe ? dut_o : (st_oe ? st_o : 1'b1);

   always #(CLK_PERIOD/2) clk = ~clk;

   mdio_phy_responder u_mdio_phy_responder (
      .clk    (clk),
      .rst_n  (rst_n),
      .mdc    (mdc),
      .mdio_i (bus),
      .link_up(link_up),
      .mdio_o (dut_o),
      .mdio_oe(dut_oe)
   );

   always @(posedge clk) if (dut_oe) oe_seen <= 1'b1;

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // monitor: compare each captured read word with the oldest expectation
   always @(negedge clk) begin
      while (got_q.size() > 0 && exp_q.size() > 0) begin
         chk(tag_q.pop_front(), got_q.pop_front(), exp_q.pop_front());
      end
   end

   task automatic mbit(input logic en, input logic v, output logic seen);
      @(negedge clk);
      mdc   = 1'b0;
      st_oe = en;
      st_o  = v;
      repeat (HALF_BIT) @(negedge clk);
      seen = bus;
      mdc  = 1'b1;
      repeat (HALF_BIT) @(negedge clk);
   endtask

   task automatic send(input int n, input logic [31:0] v);
      logic s;
      for (int i = n - 1; i >= 0; i--) mbit(1'b1, v[i], s);
   endtask

   task automatic release_line();
      @(negedge clk);
      mdc   = 1'b0;
      st_oe = 1'b0;
      repeat (HALF_BIT) @(negedge clk);
   endtask

   task automatic mwrite(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
      send(PRE, 32'hFFFF_FFFF);
      send(4, 4'b0101);
      send(5, {27'b0, phy});
      send(5, {27'b0, ra});
      send(2, 2'b10);
      send(16, {16'b0, d});
      release_line();
   endtask

   task automatic mread(input logic [4:0] phy, input logic [4:0] ra,
                        output logic [15:0] d, output logic ta1, output logic ta2,
                        output logic oe_ta2, output logic oe_end);
      logic s;
      send(PRE, 32'hFFFF_FFFF);
      send(4, 4'b0110);
      send(5, {27'b0, phy});
      send(5, {27'b0, ra});
      mbit(1'b0, 1'b1, ta1);
      mbit(1'b0, 1'b1, ta2);
      oe_ta2 = dut_oe;
      for (int i = 15; i >= 0; i--) begin
         mbit(1'b0, 1'b1, s);
         d[i] = s;
      end
      release_line();
      oe_end = dut_oe;
   endtask

   // driver: push the expectation, run the frame, hand the word to the monitor
   task automatic rd_expect(input logic [4:0] ra, input logic [15:0] exp, input string tag);
      logic [15:0] d;
      logic t1, t2, o2, oe_end;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      mread(ME, ra, d, t1, t2, o2, oe_end);
      got_q.push_back(d);
      chk({tag, " R9 ta1 released"}, {15'b0, t1}, 16'h0001);
      chk({tag, " R9 ta2 low"}, {14'b0, o2, t2}, 16'h0002);
      chk({tag, " R9 released after bit0"}, {15'b0, oe_end}, 16'h0000);
   endtask

   initial begin
      logic [15:0] d;
      logic t1, t2, o2, oe_end;
      repeat (5) @(negedge clk);
      chk("R1 line idle in reset", {15'b0, dut_oe}, 16'h0000);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk("R1 line idle after reset", {15'b0, dut_oe}, 16'h0000);

      rd_expect(5'd0, 16'h3100, "R1 reg0");
      rd_expect(5'd2, 16'h0300, "R1 reg2");
      rd_expect(5'd3, 16'hE400, "R1 reg3");
      rd_expect(5'd4, 16'h01E1, "R1 reg4");
      rd_expect(5'd9, 16'h0000, "R1 reg9");
      rd_expect(5'd1, 16'h782E, "R3 status up");
      rd_expect(5'd5, 16'h41E1, "R4 partner default");
      rd_expect(5'd17, 16'h8000, "R5 vendor");
      rd_expect(5'd18, 16'h0C00, "R6 diag default");

      mwrite(ME, 5'd9, 16'hA5C3);
      mwrite(ME, 5'd31, 16'h1234);
      rd_expect(5'd9, 16'hA5C3, "R2 reg9");
      rd_expect(5'd31, 16'h1234, "R2 reg31");

      mwrite(ME, 5'd1, 16'h0000);
      rd_expect(5'd1, 16'h782E, "R3 status ignores write");

      mwrite(ME, 5'd4, 16'h0080);
      rd_expect(5'd18, 16'h0400, "R6 diag 100 half");
      rd_expect(5'd5, 16'h4081, "R4 partner 100 half");
      mwrite(ME, 5'd4, 16'h0040);
      rd_expect(5'd18, 16'h0800, "R6 diag 10 full");
      rd_expect(5'd5, 16'h4041, "R4 partner 10 full");
      mwrite(ME, 5'd4, 16'h0020);
      rd_expect(5'd18, 16'h0000, "R6 diag 10 half");
      mwrite(ME, 5'd4, 16'h0100);
      rd_expect(5'd18, 16'h0C00, "R6 diag 100 full");
      rd_expect(5'd5, 16'h4101, "R4 partner 100 full");

      mwrite(ME, 5'd0, 16'h9140);
      rd_expect(5'd0, 16'h1140, "R7 ctrl reset bit cleared");

      // foreign address: no drive, no store
      oe_seen = 1'b0;
      mread(OTHER, 5'd9, d, t1, t2, o2, oe_end);
      mwrite(OTHER, 5'd9, 16'h0F0F);
      chk("R10 foreign never driven", {15'b0, oe_seen}, 16'h0000);
      chk("R10 foreign read floats", d, 16'hFFFF);
      rd_expect(5'd9, 16'hA5C3, "R10 foreign write ignored");

      // malformed start and opcode
      send(PRE, 32'hFFFF_FFFF);
      send(2, 2'b00);
      send(2, 2'b01);
      send(5, {27'b0, ME});
      send(5, 32'd9);
      send(2, 2'b10);
      send(16, 32'h0BAD);
      release_line();
      send(PRE, 32'hFFFF_FFFF);
      send(4, 4'b0111);
      send(5, {27'b0, ME});
      send(5, 32'd9);
      send(2, 2'b10);
      send(16, 32'h0BAD);
      release_line();
      rd_expect(5'd9, 16'hA5C3, "R11 malformed frames ignored");

      // preamble one bit short
      send(1, 32'h0);
      send(PRE - 1, 32'hFFFF_FFFF);
      send(4, 4'b0101);
      send(5, {27'b0, ME});
      send(5, 32'd9);
      send(2, 2'b10);
      send(16, 32'h0BAD);
      release_line();
      rd_expect(5'd9, 16'hA5C3, "R8 short preamble ignored");

      link_up = 1'b0;
      rd_expect(5'd1, 16'h0000, "R3 status down");
      rd_expect(5'd18, 16'h0000, "R6 diag down");
      rd_expect(5'd17, 16'h8000, "R5 vendor link down");
      rd_expect(5'd5, 16'h4101, "R4 partner link down");
      link_up = 1'b1;
      rd_expect(5'd1, 16'h782E, "R3 status up again");

      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL R8 watchdog act=hung exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule